// File: doc/BRIEF.md
# Timestamp Event Capture Unit

This unit latches a free-running 32-bit time value when a selected event fires. The event comes from one of two places. One is an edge on an asynchronous event-request input; that input is synchronized and edge-detected first. The other is a single-cycle pulse-per-second tick from inside the chip. The unit has one capture channel. It counts events in an 8-bit saturating counter. If an event arrives before software has collected the previous timestamp, the unit raises an error flag.

Software reaches the unit through a small bank of 16-bit words. It polls the status word and then reads the timestamp from the two words that follow, low half first. It writes the status word back with the valid bit cleared to re-arm capture. Every status write also restarts the event counter. The status word, both timestamp halves and the counter word sit at consecutive addresses, so one burst of four reads collects a complete capture.

Top module: `evcap_unit`

## Requirements
- R1: After reset, every word at addresses 0 to 4 reads as zero.
- R2: With status bit 2 clear and config bit 0 clear, a rising edge on `evreq_in` is captured at the third rising clock edge after the input changes. At that edge, status bit 0 (valid) is set and the time value present at the edge is stored.
- R3: With config bit 0 set, only a falling edge of `evreq_in` is captured. With config bit 0 clear, a falling edge is ignored, and with config bit 0 set, a rising edge is ignored.
- R4: With status bit 2 set, a high `pps_tick` is captured at that same clock edge and `evreq_in` edges are ignored. With status bit 2 clear, `pps_tick` is ignored.
- R5: Address 2 returns bits 15:0 of the stored time and address 3 returns bits 31:16.
- R6: Writing status bit 0 as 0 clears valid and re-arms capture. Writing it as 1 never sets valid.
- R7: An event that arrives while valid is set sets status bit 1 (error). With config bit 1 (overwrite) clear, the stored time is left unchanged.
- R8: With config bit 1 set, an event that arrives while valid is set replaces the stored time. Valid stays set and error is set.
- R9: With config bit 2 set, each event adds one to the counter, which reads back in bits 15:8 of address 4. The counter stops at 255. With config bit 2 clear, events are not counted.
- R10: Any write to the status word (address 1) clears the counter.
- R11: When a status write and an event fall in the same cycle, the write takes effect first and the event is then applied to the result. Clearing valid in that cycle therefore yields valid=1, a fresh timestamp and a counter of 1.
- R12: Writing status bit 1 as 0 clears error. Writing it as 1 leaves error unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 32 | Free-running time value to latch |
| evreq_in | input | 1 | Asynchronous external event request |
| pps_tick | input | 1 | Internal pulse-per-second tick, one cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |

## Verification
Two functions can land in the same cycle: a status write from software and a capture event. The bench provokes this by raising the write strobe and the pulse-per-second tick at the same clock edge. It sends the status write that clears valid and error while the unit holds a stale timestamp. It then expects valid set again, error clear, a counter of one and a timestamp equal to the time at that edge. That outcome is correct only if the write is ordered before the event. A unit that lets the write win would read valid clear. A unit that let the event see the old valid would report an error and keep the stale time.

// File: rtl/evcap_unit.sv
module evcap_unit #(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] time_now,
  input  logic        evreq_in,
  input  logic        pps_tick,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]       sync_q;
  logic             fall_sel, ovw_en, cnt_en;
  logic             src_pps, valid_q, err_q;
  logic [31:0]      ts_q;
  logic [CNT_W-1:0] cnt_q;

  wire cfg_wr  = reg_wr && (reg_addr == 3'd0);
  wire stat_wr = reg_wr && (reg_addr == 3'd1);
  wire rise    = sync_q[1] & ~sync_q[2];
  wire fall    = ~sync_q[1] & sync_q[2];
  wire evt     = src_pps ? pps_tick : (fall_sel ? fall : rise);

  wire             valid_w = stat_wr ? (valid_q & reg_wdata[0]) : valid_q;
  wire             err_w   = stat_wr ? (err_q & reg_wdata[1]) : err_q;
  wire [CNT_W-1:0] cnt_w   = stat_wr ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= '0;
      fall_sel <= 1'b0;
      ovw_en   <= 1'b0;
      cnt_en   <= 1'b0;
      src_pps  <= 1'b0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
      ts_q     <= '0;
      cnt_q    <= '0;
    end else begin
      sync_q <= {sync_q[1:0], evreq_in};
      if (cfg_wr) {cnt_en, ovw_en, fall_sel} <= reg_wdata[2:0];
      if (stat_wr) src_pps <= reg_wdata[2];
      valid_q <= valid_w | evt;
      err_q   <= err_w | (evt & valid_w);
      if (evt && (!valid_w || ovw_en)) ts_q <= time_now;
      cnt_q <= (evt && cnt_en && cnt_w != CNT_MAX) ? cnt_w + 1'b1 : cnt_w;
    end
  end

  wire [15:0] cnt_word = {cnt_q, {(16 - CNT_W){1'b0}}};

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {13'b0, cnt_en, ovw_en, fall_sel};
      3'd1:    reg_rdata = {13'b0, src_pps, err_q, valid_q};
      3'd2:    reg_rdata = ts_q[15:0];
      3'd3:    reg_rdata = ts_q[31:16];
      3'd4:    reg_rdata = cnt_word;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module evcap_unit_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt,
  input logic             stat_wr,
  input logic             valid_q,
  input logic             err_q,
  input logic [31:0]      ts_q,
  input logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  capture_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> valid_q);
  // R7
  late_event_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt && valid_q && !stat_wr |=> err_q);
  // R6
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(evt));
  // R7
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(ts_q));
  // R9
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_MAX && !stat_wr |=> cnt_q == CNT_MAX);
  // R10
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && !evt |=> cnt_q == '0);
endmodule

bind evcap_unit evcap_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .stat_wr(stat_wr),
  .valid_q(valid_q), .err_q(err_q), .ts_q(ts_q), .cnt_q(cnt_q)
);

// File: tb/evcap_unit_test.sv
`timescale 1ns/1ps
module evcap_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tnow = 32'hA5A4_FFF8;
  logic        evreq_in = 1'b0;
  logic        pps_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int n_run = 0;
  int n_fail = 0;

  evcap_unit uut (
    .clk(clk), .rst_n(rst_n), .time_now(tnow), .evreq_in(evreq_in),
    .pps_tick(pps_tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #4 clk = ~clk;
  always @(posedge clk) tnow <= tnow + 1;

  // fields: [7:5] config, [4] source, [3:2] stimulus (0 rise, 1 fall, 2 pps), [0] capture expected
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{
    {3'b000, 1'b0, 2'd0, 1'b0, 1'b1},
    {3'b000, 1'b0, 2'd1, 1'b0, 1'b0},
    {3'b001, 1'b0, 2'd1, 1'b0, 1'b1},
    {3'b001, 1'b0, 2'd0, 1'b0, 1'b0},
    {3'b000, 1'b1, 2'd2, 1'b0, 1'b1},
    {3'b000, 1'b1, 2'd0, 1'b0, 1'b0},
    {3'b000, 1'b0, 2'd2, 1'b0, 1'b0},
    {3'b110, 1'b0, 2'd0, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pps_pulse(output logic [31:0] t);
    @(negedge clk);
    pps_tick = 1'b1;
    @(negedge clk);
    t = tnow - 1;
    pps_tick = 1'b0;
  endtask

  task automatic ext_drive(input logic lvl, output logic [31:0] t);
    @(negedge clk);
    evreq_in = lvl;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t = tnow - 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d, lo, hi;
    logic [31:0] t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], d);
      check("R1 reset word", {16'h0, d}, 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      evreq_in = (VEC[i][3:2] == 2'd1);
      repeat (4) @(negedge clk);
      wr(3'd0, {13'b0, VEC[i][7:5]});
      wr(3'd1, {13'b0, VEC[i][4], 2'b00});
      if (VEC[i][3:2] == 2'd2) pps_pulse(t1);
      else ext_drive(VEC[i][3:2] == 2'd0, t1);
      repeat (3) @(negedge clk);
      rd(3'd1, d);
      check($sformatf("R2 R3 R4 vector %0d valid", i), {31'b0, d[0]}, {31'b0, VEC[i][0]});
      if (VEC[i][0]) begin
        rd(3'd2, lo);
        rd(3'd3, hi);
        check($sformatf("R5 vector %0d low half", i), {16'h0, lo}, {16'h0, t1[15:0]});
        check($sformatf("R5 vector %0d high half", i), {16'h0, hi}, {16'h0, t1[31:16]});
      end
    end
    evreq_in = 1'b0;
    repeat (4) @(negedge clk);

    wr(3'd0, 16'h0004);
    wr(3'd1, 16'h0004);
    pps_pulse(t1);
    pps_pulse(t2);
    rd(3'd1, d);
    check("R7 status after late event", {16'h0, d}, 32'h7);
    rd(3'd2, lo); rd(3'd3, hi);
    check("R7 stored time kept", {hi, lo}, t1);
    rd(3'd4, d);
    check("R9 count two events", {16'h0, d}, 32'h0200);

    wr(3'd1, 16'h0007);
    rd(3'd1, d);
    check("R6 R12 write ones keeps flags", {16'h0, d}, 32'h7);
    rd(3'd4, d);
    check("R10 status write clears count", {16'h0, d}, 32'h0);
    wr(3'd1, 16'h0005);
    rd(3'd1, d);
    check("R12 error cleared", {16'h0, d}, 32'h5);
    wr(3'd1, 16'h0004);
    rd(3'd1, d);
    check("R6 valid cleared", {16'h0, d}, 32'h4);
    wr(3'd1, 16'h0005);
    rd(3'd1, d);
    check("R6 writing one does not set valid", {16'h0, d}, 32'h4);
    pps_pulse(t1);
    rd(3'd1, d);
    check("R6 re-armed capture", {16'h0, d}, 32'h5);
    rd(3'd2, lo); rd(3'd3, hi);
    check("R6 new time", {hi, lo}, t1);

    wr(3'd0, 16'h0006);
    wr(3'd1, 16'h0004);
    pps_pulse(t1);
    pps_pulse(t2);
    rd(3'd1, d);
    check("R8 status after overwrite", {16'h0, d}, 32'h7);
    rd(3'd2, lo); rd(3'd3, hi);
    check("R8 time replaced", {hi, lo}, t2);

    wr(3'd0, 16'h0004);
    wr(3'd1, 16'h0004);
    @(negedge clk);
    pps_tick = 1'b1;
    repeat (260) @(posedge clk);
    @(negedge clk);
    pps_tick = 1'b0;
    rd(3'd4, d);
    check("R9 counter saturates", {16'h0, d}, 32'hFF00);
    wr(3'd1, 16'h0004);
    rd(3'd4, d);
    check("R10 clear after saturation", {16'h0, d}, 32'h0);

    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0004);
    pps_pulse(t1);
    pps_pulse(t1);
    pps_pulse(t1);
    rd(3'd4, d);
    check("R9 counting disabled", {16'h0, d}, 32'h0);

    wr(3'd0, 16'h0004);
    wr(3'd1, 16'h0004);
    pps_pulse(t1);
    pps_pulse(t1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 16'h0004; pps_tick = 1'b1;
    @(negedge clk);
    t2 = tnow - 1;
    reg_wr = 1'b0; pps_tick = 1'b0;
    rd(3'd1, d);
    check("R11 write then event status", {16'h0, d}, 32'h5);
    rd(3'd2, lo); rd(3'd3, hi);
    check("R11 fresh time", {hi, lo}, t2);
    rd(3'd4, d);
    check("R11 count restarts at one", {16'h0, d}, 32'h0100);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule